// File: doc/BRIEF.md
# Reverse-Subtract-With-Carry Execute Slice

This block is the execute stage for one 32-bit data-processing instruction: the second operand minus the first, minus the inverted carry. It takes the instruction word, the two source values already read from the register file, the current carry flag and an externally computed condition-pass bit.

The word is checked for the fixed opcode pattern and its fields are decoded. The immediate shift or rotate is applied to the second source value. An add-with-carry of the inverted first operand, the shifted value and the carry produces the result and four new flags. Enables for register write and flag write are produced alongside, and a destination of register 15 becomes either a branch request or an exception-return request.

All outputs are registered, one cycle after the inputs are presented. The enclosing pipeline performs the register write, flag update, branch or return.

Top module: `rsc_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are cleared to zero on that edge, including every enable and request.
- R2: A word is accepted only when bits [31:28] are not 1111, bits [27:24] are 0000, bits [23:21] are 111 and bit 4 is 0. Any other word deasserts all enables and requests.
- R3: `res_q` equals shifted operand minus `opa_val` minus (1 - `carry_in`), taken modulo 2^32.
- R4: The shift kind is taken from bits [6:5] and the count from bits [11:7]. The kinds are 00 left shift, 01 logical right, 10 arithmetic right and 11 rotate right, applied to `opb_val`. A left shift by 0 leaves the value unchanged.
- R5: A count field of 0 with logical or arithmetic right shift means a shift by 32: all zero bits for logical right, and all copies of bit 31 for arithmetic right.
- R6: A count field of 0 with rotate right means a one-bit rotate through carry: `carry_in` goes to bit 31 and `opb_val[31:1]` goes to bits 30:0.
- R7: `flags_q` is {N,Z,C,V} in bits [3:0]. N is result bit 31. Z is set when the result is zero. C is 1 when no borrow occurs. V is signed overflow of the subtraction.
- R8: For an accepted word with condition pass, the destination is bits [15:12] and appears on `dest_idx_q`. If the destination is not 15, `reg_we_q` is set, and `flag_we_q` is set exactly when bit 20 (S) is 1.
- R9: Destination 15 with S=0 sets `branch_req_q`, with no register or flag write.
- R10: Destination 15 with S=1 sets `eret_req_q`, with no register or flag write. `res_q` carries the return address.
- R11: When `cond_ok` is low, all enables and requests are deasserted in the next cycle.
- R12: Every output reflects the inputs present at the previous rising edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 32 | Instruction word |
| opa_val | input | 32 | First source value (subtrahend) |
| opb_val | input | 32 | Second source value (shifted) |
| carry_in | input | 1 | Current carry flag |
| cond_ok | input | 1 | Condition check passed |
| res_q | output | 32 | Result / branch or return target |
| dest_idx_q | output | 4 | Destination register index |
| reg_we_q | output | 1 | Register write enable |
| flag_we_q | output | 1 | Flag write enable |
| flags_q | output | 4 | New flags {N,Z,C,V} |
| branch_req_q | output | 1 | Branch to `res_q` |
| eret_req_q | output | 1 | Exception return to `res_q` |

## Verification
The bound checker watches the control outputs on every cycle. It checks that a register write, a branch and a return are never requested together, that a flag write never comes without a register write, that a failed condition or a malformed word silences every enable, and that the destination index has one cycle of latency. It also checks the N and Z flags against the result, and the arithmetic of the rotate-through-carry case. Only the bench's sweep over every shift kind, every count and both carry values, with several operand patterns, can show that each shift amount and the C and V flags come out right.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   localparam int INSTR_W = 32;

   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   typedef struct packed {
      logic        fmt_ok;
      logic        set_flags;
      logic [3:0]  dst;
      shift_kind_e kind;
      logic [5:0]  amount;
   } rsc_decoded_t;
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
   import rsc_pkg::*;
(
   input  logic [INSTR_W-1:0] word,
   output rsc_decoded_t       dec
);
   logic [4:0] cnt;
   logic [1:0] styp;

   assign cnt  = word[11:7];
   assign styp = word[6:5];

   always_comb begin
      dec.fmt_ok    = (word[31:28] != 4'hF) && (word[27:24] == 4'h0) &&
                      (word[23:21] == 3'b111) && !word[4];
      dec.set_flags = word[20];
      dec.dst       = word[15:12];
      dec.amount    = {1'b0, cnt};
      unique case (styp)
         2'b00: dec.kind = SK_LSL;
         2'b01: begin
            dec.kind = SK_LSR;
            if (cnt == 5'd0) dec.amount = 6'd32;
         end
         2'b10: begin
            dec.kind = SK_ASR;
            if (cnt == 5'd0) dec.amount = 6'd32;
         end
         default: dec.kind = (cnt == 5'd0) ? SK_RRX : SK_ROR;
      endcase
   end
endmodule

// File: rtl/rsc_shifter.sv
module rsc_shifter
   import rsc_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W) + 1
)(
   input  logic [DATA_W-1:0] din,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amount,
   input  logic              cin,
   output logic [DATA_W-1:0] dout
);
   logic [2*DATA_W-1:0] dbl;
   logic [2*DATA_W-1:0] rot_wide;

   assign dbl      = {din, din};
   assign rot_wide = dbl >> amount;

   always_comb begin
      unique case (kind)
         SK_LSL:  dout = din << amount;
         SK_LSR:  dout = din >> amount;
         SK_ASR:  dout = DATA_W'($signed(din) >>> amount);
         SK_ROR:  dout = rot_wide[DATA_W-1:0];
         SK_RRX:  dout = {cin, din[DATA_W-1:1]};
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/rsc_addc.sv
module rsc_addc #(
   parameter int DATA_W = 32
)(
   input  logic [DATA_W-1:0] inv_src,
   input  logic [DATA_W-1:0] shf_src,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic [3:0]        nzcv
);
   logic [DATA_W:0] wide;

   assign wide = {1'b0, inv_src} + {1'b0, shf_src} + {{DATA_W{1'b0}}, cin};
   assign sum  = wide[DATA_W-1:0];

   always_comb begin
      nzcv[3] = sum[DATA_W-1];
      nzcv[2] = (sum == '0);
      nzcv[1] = wide[DATA_W];
      nzcv[0] = (inv_src[DATA_W-1] == shf_src[DATA_W-1]) &&
                (sum[DATA_W-1] != shf_src[DATA_W-1]);
   end
endmodule

// File: rtl/rsc_exec_unit.sv
module rsc_exec_unit
   import rsc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   localparam int AMT_W = $clog2(DATA_W) + 1,
   localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}}
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic [DATA_W-1:0] opa_val,
   input  logic [DATA_W-1:0] opb_val,
   input  logic              carry_in,
   input  logic              cond_ok,
   output logic [DATA_W-1:0] res_q,
   output logic [IDX_W-1:0]  dest_idx_q,
   output logic              reg_we_q,
   output logic              flag_we_q,
   output logic [3:0]        flags_q,
   output logic              branch_req_q,
   output logic              eret_req_q
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("rsc_exec_unit: DATA_W must be 32 to match the 5-bit count field");
      end
      if (IDX_W != 4) begin : g_bad_idx
         $error("rsc_exec_unit: IDX_W must be 4 to match the destination field");
      end
   endgenerate

   rsc_decoded_t      dec;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] sum;
   logic [3:0]        nzcv;
   logic              live;
   logic              to_pc;

   rsc_decode u_dec (
      .word (instr_word),
      .dec  (dec)
   );

   rsc_shifter #(.DATA_W(DATA_W)) u_shf (
      .din    (opb_val),
      .kind   (dec.kind),
      .amount (AMT_W'(dec.amount)),
      .cin    (carry_in),
      .dout   (shifted)
   );

   rsc_addc #(.DATA_W(DATA_W)) u_add (
      .inv_src (~opa_val),
      .shf_src (shifted),
      .cin     (carry_in),
      .sum     (sum),
      .nzcv    (nzcv)
   );

   assign live  = cond_ok && dec.fmt_ok;
   assign to_pc = (IDX_W'(dec.dst) == PC_IDX);

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q        <= '0;
         dest_idx_q   <= '0;
         reg_we_q     <= 1'b0;
         flag_we_q    <= 1'b0;
         flags_q      <= '0;
         branch_req_q <= 1'b0;
         eret_req_q   <= 1'b0;
      end else begin
         res_q        <= sum;
         dest_idx_q   <= IDX_W'(dec.dst);
         flags_q      <= nzcv;
         reg_we_q     <= live && !to_pc;
         flag_we_q    <= live && !to_pc && dec.set_flags;
         branch_req_q <= live && to_pc && !dec.set_flags;
         eret_req_q   <= live && to_pc && dec.set_flags;
      end
   end
endmodule

// File: rtl/rsc_exec_checker.sv
module rsc_exec_checker #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
)(
   input logic              clk,
   input logic              rst,
   input logic [31:0]       instr_word,
   input logic [DATA_W-1:0] opa_val,
   input logic [DATA_W-1:0] opb_val,
   input logic              carry_in,
   input logic              cond_ok,
   input logic [DATA_W-1:0] res_q,
   input logic [IDX_W-1:0]  dest_idx_q,
   input logic              reg_we_q,
   input logic              flag_we_q,
   input logic [3:0]        flags_q,
   input logic              branch_req_q,
   input logic              eret_req_q
);
   logic word_ok;
   logic any_act;
   logic rrx_word;

   assign word_ok  = (instr_word[31:28] != 4'hF) && (instr_word[27:21] == 7'b0000111) &&
                     !instr_word[4];
   assign any_act  = reg_we_q || flag_we_q || branch_req_q || eret_req_q;
   assign rrx_word = (instr_word[11:7] == 5'd0) && (instr_word[6:5] == 2'b11);

   p_excl_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({reg_we_q, branch_req_q, eret_req_q}));

   p_flag_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
      flag_we_q |-> reg_we_q);

   p_cond_gate_r11: assert property (@(posedge clk) disable iff (rst)
      !cond_ok |=> !any_act);

   p_bad_word_r2: assert property (@(posedge clk) disable iff (rst)
      !word_ok |=> !any_act);

   p_pc_dest_r10: assert property (@(posedge clk) disable iff (rst)
      (cond_ok && word_ok && instr_word[15:12] == 4'hF) |=>
      (!reg_we_q && (branch_req_q || eret_req_q)));

   p_latency_r12: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (dest_idx_q == $past(instr_word[15:12])));

   p_nz_r7: assert property (@(posedge clk) disable iff (rst)
      flag_we_q |-> ((flags_q[2] == (res_q == '0)) && (flags_q[3] == res_q[DATA_W-1])));

   p_rrx_r6: assert property (@(posedge clk) disable iff (rst)
      (!rst && rrx_word) |=>
      (res_q == ({$past(carry_in), $past(opb_val[DATA_W-1:1])} - $past(opa_val)
                 - {{(DATA_W-1){1'b0}}, ~$past(carry_in)})));
endmodule

bind rsc_exec_unit rsc_exec_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/rsc_exec_unit_test.sv
`timescale 1ns/1ps
module rsc_exec_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_word = '0;
   logic [31:0] opa_val = '0;
   logic [31:0] opb_val = '0;
   logic        carry_in = 1'b0;
   logic        cond_ok = 1'b0;
   logic [31:0] res_q;
   logic [3:0]  dest_idx_q;
   logic        reg_we_q, flag_we_q, branch_req_q, eret_req_q;
   logic [3:0]  flags_q;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   rsc_exec_unit uut (.*);

   function automatic logic [31:0] mk(input logic [3:0] cnd, input logic s,
                                      input logic [3:0] rd, input logic [4:0] cnt,
                                      input logic [1:0] st);
      return {cnd, 4'b0000, 3'b111, s, 4'h2, rd, cnt, st, 1'b0, 4'h5};
   endfunction

   // bit-at-a-time reference shifter
   function automatic logic [31:0] ref_shift(input logic [31:0] x, input logic [1:0] st,
                                             input logic [4:0] cnt, input logic c);
      logic [31:0] v = x;
      int n = int'(cnt);
      if (st == 2'b11 && cnt == 0) return {c, x[31:1]};
      if ((st == 2'b01 || st == 2'b10) && cnt == 0) n = 32;
      for (int i = 0; i < n; i++) begin
         case (st)
            2'b00: v = {v[30:0], 1'b0};
            2'b01: v = {1'b0, v[31:1]};
            2'b10: v = {v[31], v[31:1]};
            default: v = {v[0], v[31:1]};
         endcase
      end
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        input logic c, input logic cok);
      @(negedge clk);
      instr_word = w; opa_val = a; opb_val = b; carry_in = c; cond_ok = cok;
      @(posedge clk);
      #1;
   endtask

   logic [31:0] pats_a [3] = '{32'h0000_0001, 32'h8000_0000, 32'h1234_5678};
   logic [31:0] pats_b [3] = '{32'hF0F0_0F0F, 32'h7FFF_FFFF, 32'h8000_0001};

   initial begin
      // R1 reset state, with a live word presented during reset
      @(negedge clk);
      instr_word = mk(4'hE, 1'b1, 4'h3, 5'd1, 2'b00); opa_val = 32'h5; opb_val = 32'h9;
      carry_in = 1'b1; cond_ok = 1'b1;
      @(posedge clk); #1;
      chk(res_q == 0 && flags_q == 0 && dest_idx_q == 0, "R1 data clear", res_q, 0);
      chk({reg_we_q, flag_we_q, branch_req_q, eret_req_q} == 0, "R1 enables clear",
          {28'b0, reg_we_q, flag_we_q, branch_req_q, eret_req_q}, 0);
      @(negedge clk); rst = 1'b0;

      // R3 R4 R5 R6 R7 R12: sweep every kind, count and carry
      for (int p = 0; p < 3; p++) begin
         for (int st = 0; st < 4; st++) begin
            for (int cnt = 0; cnt < 32; cnt++) begin
               for (int c = 0; c < 2; c++) begin
                  logic [31:0] a, b, sh, exp;
                  longint dif, sdif;
                  logic [3:0] ef;
                  a = pats_a[p]; b = pats_b[(p + st) % 3];
                  sh = ref_shift(b, 2'(st), 5'(cnt), 1'(c));
                  dif  = longint'(sh) - longint'(a) - longint'(1 - c);
                  sdif = longint'($signed(sh)) - longint'($signed(a)) - longint'(1 - c);
                  exp = dif[31:0];
                  ef = {exp[31], exp == 0, dif >= 0,
                        (sdif > 64'sd2147483647) || (sdif < -64'sd2147483648)};
                  apply(mk(4'h0, 1'b1, 4'h7, 5'(cnt), 2'(st)), a, b, 1'(c), 1'b1);
                  if (st == 3 && cnt == 0)
                     chk(res_q == exp, "R6 rrx result", res_q, exp);
                  else if ((st == 1 || st == 2) && cnt == 0)
                     chk(res_q == exp, "R5 shift-by-32 result", res_q, exp);
                  else
                     chk(res_q == exp, "R3 R4 result", res_q, exp);
                  chk(flags_q == ef, "R7 flags", {28'b0, flags_q}, {28'b0, ef});
               end
            end
         end
      end

      // R2 R8 R9 R10 R11: control sweep
      for (int rdi = 0; rdi < 2; rdi++) begin
         for (int s = 0; s < 2; s++) begin
            for (int cok = 0; cok < 2; cok++) begin
               for (int bad = 0; bad < 4; bad++) begin
                  logic [31:0] w;
                  logic [3:0] rd;
                  bit live, pc;
                  logic [3:0] exp_ctl;
                  rd = (rdi == 0) ? 4'h3 : 4'hF;
                  w = mk(4'hA, 1'(s), rd, 5'd4, 2'b01);
                  if (bad == 1) w[31:28] = 4'hF;
                  if (bad == 2) w[4] = 1'b1;
                  if (bad == 3) w[22] = 1'b0;
                  live = (cok == 1) && (bad == 0);
                  pc = (rd == 4'hF);
                  exp_ctl = {live && !pc, live && !pc && s == 1, live && pc && s == 0,
                             live && pc && s == 1};
                  apply(w, 32'h10, 32'h100, 1'b1, 1'(cok));
                  chk({reg_we_q, flag_we_q, branch_req_q, eret_req_q} == exp_ctl,
                      (bad != 0) ? "R2 bad word" : (cok == 0) ? "R11 cond fail" :
                      pc ? (s ? "R10 eret" : "R9 branch") : "R8 write enables",
                      {28'b0, reg_we_q, flag_we_q, branch_req_q, eret_req_q},
                      {28'b0, exp_ctl});
                  chk(dest_idx_q == rd, "R8 R12 dest index", {28'b0, dest_idx_q}, {28'b0, rd});
                  if (live && pc)
                     chk(res_q == 32'h10 - 32'h10, "R10 target value", res_q, 32'h0);
               end
            end
         end
      end

      // R4: left shift by zero leaves operand unchanged
      apply(mk(4'h1, 1'b0, 4'h1, 5'd0, 2'b00), 32'h0, 32'hDEAD_BEEF, 1'b1, 1'b1);
      chk(res_q == 32'hDEAD_BEEF, "R4 lsl0 passthrough", res_q, 32'hDEAD_BEEF);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R12 actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule